// File: doc/BRIEF.md
# Memory ECC Error Logging Registers

This block records DRAM ECC error events that an external checker reports. A single-bit (corrected) pulse or a multi-bit (uncorrectable) pulse arrives together with the failing 33-bit physical address, the channel of the access and the 8-bit syndrome. The block keeps a status word, a command word that enables a system-error output for each event class, and a capture of address, channel and syndrome. Refresh timeout, locked access to non-DRAM memory and thermal events come in as plain pulses and only set status bits.

Software reaches the registers through a word-addressed bus with byte enables and a combinational read path. Status bits are cleared by writing 1. An uncorrectable error replaces the capture of a pending corrected error. A corrected error never replaces an existing capture. The system-error output is a registered OR of every status bit that is enabled in the command word.

Top module: `ecc_err_log`

## Requirements
- R1: A pulse on `ceEvt` sets status bit 0 and a pulse on `ueEvt` sets status bit 1, one clock after the pulse. Status occupies bits 15:0 of word 0 (`regSel`=0).
- R2: Pulses on `rtoEvt`, `lckEvt` and `thmEvt` set status bits 8, 9 and 11. Every other status bit always reads 0, so the status mask is 0x0B03.
- R3: A write to word 0 clears each status bit for which byte enable 0 or 1 is set and the data bit is 1. A data bit of 0 leaves the status bit as it was.
- R4: When a corrected error arrives and nothing is logged (status bits 0 and 1 both clear), the capture is loaded. Word 1 then holds address bits 31:7 in bits 31:7, zero in bits 6:1 and the channel in bit 0. Word 2 holds the syndrome in bits 7:0, address bit 32 in bit 8 and zero in bits 31:9.
- R5: An uncorrectable error with status bit 1 clear loads the capture, even if a corrected error is pending. Both status bits then stay set.
- R6: A corrected error while status bit 0 or 1 is set changes only the status. A second uncorrectable error while bit 1 is set keeps the first capture.
- R7: The command word sits in bits 31:16 of word 0 and is written through byte enables 2 and 3. Only bits 0, 1, 8, 9 and 11 are held, and all other bits read 0.
- R8: `serr` is high one clock after any status bit and its command bit are both 1. It drops one clock after that status bit is cleared.
- R9: When an event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R10: After reset, every register reads 0 and `serr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceEvt | input | 1 | Corrected (single-bit) ECC error pulse |
| ueEvt | input | 1 | Uncorrectable (multi-bit) ECC error pulse |
| rtoEvt | input | 1 | Refresh timeout event pulse |
| lckEvt | input | 1 | Locked access to non-DRAM memory event pulse |
| thmEvt | input | 1 | Thermal sensor event pulse |
| errAddr | input | 33 | Physical address of the failing access |
| errChan | input | 1 | Channel of the failing access |
| errSyn | input | 8 | ECC syndrome of the failing access |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Word select: 0 status/command, 1 address, 2 syndrome/extended |
| byteEn | input | 4 | Byte enables for writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected word |
| serr | output | 1 | System-error output |

## Verification
On every cycle the assertions check that event pulses set their status bits, that bit 0 holds unless it is written with 1 or pulsed, and that reserved status and command bits stay zero. They also check that an uncorrectable error with no uncorrectable error pending reloads the capture, that a corrected error over a pending log leaves the capture alone, and that `serr` follows the enabled status one cycle later. Only the bench scenarios show the register layouts seen through the bus, the full sequence of corrected, then uncorrectable, then further errors with different addresses, the collision between a clear and an event on the non-ECC bits, and the sweep of every event class against its enable.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int STS_W      = 16;
  localparam int DATA_W     = 32;
  localparam int PHYS_W     = 33;
  localparam int SYN_W      = 8;
  localparam int SEL_W      = 2;
  localparam int GRAIN_LSB  = 7;
  localparam int STS_BYTES  = STS_W / 8;

  localparam logic [STS_W-1:0] EVT_MASK = 16'h0B03;
  localparam int BIT_CE  = 0;
  localparam int BIT_UE  = 1;
  localparam int BIT_RTO = 8;
  localparam int BIT_LCK = 9;
  localparam int BIT_THM = 11;

  localparam logic [SEL_W-1:0] SEL_CTL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_PTR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_EXT = 2'd2;

  typedef struct packed {
    logic                 capture;
    logic [STS_W-1:0]     setMask;
    logic [STS_W-1:0]     clrMask;
    logic [STS_BYTES-1:0] cmdByteWr;
  } strobe_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic                 ceEvt,
  input  logic                 ueEvt,
  input  logic                 rtoEvt,
  input  logic                 lckEvt,
  input  logic                 thmEvt,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     regSel,
  input  logic [3:0]           byteEn,
  input  logic [STS_W-1:0]     wrLow,
  input  logic [1:0]           pendQ,
  output strobe_t              stb
);
  logic ctlWr;
  logic anyLogged;

  assign ctlWr     = wrEn && (regSel == SEL_CTL);
  assign anyLogged = pendQ[BIT_CE] | pendQ[BIT_UE];

  always_comb begin
    stb = '0;
    stb.setMask[BIT_CE]  = ceEvt;
    stb.setMask[BIT_UE]  = ueEvt;
    stb.setMask[BIT_RTO] = rtoEvt;
    stb.setMask[BIT_LCK] = lckEvt;
    stb.setMask[BIT_THM] = thmEvt;
    for (int b = 0; b < STS_BYTES; b++) begin
      if (ctlWr && byteEn[b]) stb.clrMask[8*b +: 8] = wrLow[8*b +: 8];
    end
    stb.clrMask   = stb.clrMask & EVT_MASK;
    stb.cmdByteWr = ctlWr ? byteEn[3:2] : '0;
    stb.capture   = (ueEvt && !pendQ[BIT_UE]) || (ceEvt && !anyLogged);
  end
endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [PHYS_W-1:GRAIN_LSB] capAddr,
  input  logic                      errChan,
  input  logic [SYN_W-1:0]          errSyn,
  input  logic [SEL_W-1:0]          regSel,
  input  logic [STS_W-1:0]          wrHigh,
  output logic [DATA_W-1:0]         rdData,
  output logic                      serrQ,
  output logic [STS_W-1:0]          statusQ,
  output logic [STS_W-1:0]          cmdQ,
  output logic [DATA_W-1:0]         ptrQ,
  output logic [7:0]                extQ,
  output logic [SYN_W-1:0]          synQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      serrQ   <= 1'b0;
    end else begin
      statusQ <= ((statusQ & ~stb.clrMask) | stb.setMask) & EVT_MASK;
      serrQ   <= |(statusQ & cmdQ);
    end
  end

  for (genvar b = 0; b < STS_BYTES; b++) begin : g_cmdByte
    always_ff @(posedge clk) begin
      if (!rstN) cmdQ[8*b +: 8] <= '0;
      else if (stb.cmdByteWr[b]) cmdQ[8*b +: 8] <= wrHigh[8*b +: 8] & EVT_MASK[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
      extQ <= '0;
      synQ <= '0;
    end else if (stb.capture) begin
      ptrQ <= {capAddr[DATA_W-1:GRAIN_LSB], {(GRAIN_LSB-1){1'b0}}, errChan};
      extQ <= {7'b0, capAddr[PHYS_W-1]};
      synQ <= errSyn;
    end
  end

  always_comb begin
    case (regSel)
      SEL_CTL: rdData = {cmdQ, statusQ};
      SEL_PTR: rdData = ptrQ;
      SEL_EXT: rdData = {{(DATA_W-16){1'b0}}, extQ, synQ};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceEvt,
  input  logic              ueEvt,
  input  logic              rtoEvt,
  input  logic              lckEvt,
  input  logic              thmEvt,
  input  logic [32:0]       errAddr,
  input  logic              errChan,
  input  logic [7:0]        errSyn,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [3:0]        byteEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              serr
);
  strobe_t           stb;
  logic [STS_W-1:0]  statusQ;
  logic [STS_W-1:0]  cmdQ;
  logic [DATA_W-1:0] ptrQ;
  logic [7:0]        extQ;
  logic [SYN_W-1:0]  synQ;

  ecc_log_ctrl u_ctrl (
    .ceEvt  (ceEvt),
    .ueEvt  (ueEvt),
    .rtoEvt (rtoEvt),
    .lckEvt (lckEvt),
    .thmEvt (thmEvt),
    .wrEn   (wrEn),
    .regSel (regSel),
    .byteEn (byteEn),
    .wrLow  (wrData[STS_W-1:0]),
    .pendQ  (statusQ[1:0]),
    .stb    (stb)
  );

  ecc_log_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .capAddr (errAddr[PHYS_W-1:GRAIN_LSB]),
    .errChan (errChan),
    .errSyn  (errSyn),
    .regSel  (regSel),
    .wrHigh  (wrData[DATA_W-1:STS_W]),
    .rdData  (rdData),
    .serrQ   (serr),
    .statusQ (statusQ),
    .cmdQ    (cmdQ),
    .ptrQ    (ptrQ),
    .extQ    (extQ),
    .synQ    (synQ)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ceEvt,
  input logic        ueEvt,
  input logic        ceClr,
  input logic [31:7] capAddr,
  input logic [7:0]  errSyn,
  input logic [15:0] statusQ,
  input logic [15:0] cmdQ,
  input logic [31:0] ptrQ,
  input logic [7:0]  synQ,
  input logic        serr
);
  // R1
  ce_set_chk: assert property (@(posedge clk) disable iff (!rstN) ceEvt |=> statusQ[0]);
  // R1
  ue_set_chk: assert property (@(posedge clk) disable iff (!rstN) ueEvt |=> statusQ[1]);
  // R3
  w1c_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceEvt && !ceClr) |=> statusQ[0] == $past(statusQ[0]));
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceClr && !ceEvt) |=> !statusQ[0]);
  // R9
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceClr && ceEvt) |=> statusQ[0]);
  // R5
  ue_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ueEvt && !statusQ[1]) |=> (ptrQ[31:7] == $past(capAddr)) && (synQ == $past(errSyn)));
  // R6
  ce_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceEvt && !ueEvt && (statusQ[0] || statusQ[1])) |=> $stable(ptrQ) && $stable(synQ));
  // R8
  serr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> serr == $past(|(statusQ & cmdQ)));

  always_comb begin
    if (rstN) begin
      // R2
      sts_reserved_chk: assert ((statusQ & ~16'h0B03) == 16'h0);
      // R7
      cmd_reserved_chk: assert ((cmdQ & ~16'h0B03) == 16'h0);
    end
  end
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ceEvt   (ceEvt),
  .ueEvt   (ueEvt),
  .ceClr   (wrEn && (regSel == 2'd0) && byteEn[0] && wrData[0]),
  .capAddr (errAddr[31:7]),
  .errSyn  (errSyn),
  .statusQ (statusQ),
  .cmdQ    (cmdQ),
  .ptrQ    (ptrQ),
  .synQ    (synQ),
  .serr    (serr)
);

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceEvt = 0, ueEvt = 0, rtoEvt = 0, lckEvt = 0, thmEvt = 0;
  logic [32:0] errAddr = '0;
  logic        errChan = 0;
  logic [7:0]  errSyn = '0;
  logic        wrEn = 0;
  logic [1:0]  regSel = '0;
  logic [3:0]  byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        serr;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rstN(rstN), .ceEvt(ceEvt), .ueEvt(ueEvt), .rtoEvt(rtoEvt),
    .lckEvt(lckEvt), .thmEvt(thmEvt), .errAddr(errAddr), .errChan(errChan),
    .errSyn(errSyn), .wrEn(wrEn), .regSel(regSel), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .serr(serr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = rdData;
  endtask

  // ev bit order: {thm, lck, rto, ue, ce}
  task automatic pulse(input logic [4:0] ev, input logic [32:0] a, input logic ch, input logic [7:0] s);
    @(negedge clk);
    {thmEvt, lckEvt, rtoEvt, ueEvt, ceEvt} = ev;
    errAddr = a; errChan = ch; errSyn = s;
    @(negedge clk);
    {thmEvt, lckEvt, rtoEvt, ueEvt, ceEvt} = '0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; regSel = sel; byteEn = be; wrData = d;
    @(negedge clk);
    wrEn = 0; byteEn = '0;
  endtask

  function automatic logic [31:0] ptrOf(input logic [32:0] a, input logic ch);
    return {a[31:7], 6'b0, ch};
  endfunction

  function automatic logic [31:0] extOf(input logic [32:0] a, input logic [7:0] s);
    return {23'b0, a[32], s};
  endfunction

  initial begin
    logic [31:0] v;
    int evBits[5] = '{0, 1, 8, 9, 11};
    logic [32:0] a1 = 33'h1_DEAD_BEEF, a2 = 33'h0_1234_5680, a3 = 33'h0_CAFE_F00D, a4 = 33'h1_0000_0080;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10 reset state
    rd(2'd0, v); chk("R10 word0", v, 32'h0);
    rd(2'd1, v); chk("R10 word1", v, 32'h0);
    rd(2'd2, v); chk("R10 word2", v, 32'h0);
    chk("R10 serr", {31'b0, serr}, 32'h0);

    // R1 R4 corrected error with nothing logged
    pulse(5'b00001, a1, 1'b1, 8'h5A);
    rd(2'd0, v); chk("R1 ce status", v, 32'h1);
    rd(2'd1, v); chk("R4 ptr", v, ptrOf(a1, 1'b1));
    rd(2'd2, v); chk("R4 ext/syn", v, extOf(a1, 8'h5A));

    // R6 second CE keeps capture
    pulse(5'b00001, a2, 1'b0, 8'h11);
    rd(2'd1, v); chk("R6 ptr after ce", v, ptrOf(a1, 1'b1));
    rd(2'd2, v); chk("R6 syn after ce", v, extOf(a1, 8'h5A));

    // R5 UE replaces pending CE capture
    pulse(5'b00010, a2, 1'b0, 8'hC3);
    rd(2'd0, v); chk("R5 both bits", v, 32'h3);
    rd(2'd1, v); chk("R5 ptr", v, ptrOf(a2, 1'b0));
    rd(2'd2, v); chk("R5 ext/syn", v, extOf(a2, 8'hC3));

    // R6 CE and UE while UE logged keep capture
    pulse(5'b00001, a3, 1'b1, 8'h77);
    pulse(5'b00010, a4, 1'b1, 8'h99);
    rd(2'd1, v); chk("R6 ptr kept", v, ptrOf(a2, 1'b0));
    rd(2'd2, v); chk("R6 syn kept", v, extOf(a2, 8'hC3));

    // R3 write 0 has no effect, write 1 clears selectively
    wr(2'd0, 4'b0011, 32'h0);
    rd(2'd0, v); chk("R3 zero write", v, 32'h3);
    wr(2'd0, 4'b0011, 32'h2);
    rd(2'd0, v); chk("R3 clear bit1", v, 32'h1);
    wr(2'd0, 4'b0010, 32'h1);
    rd(2'd0, v); chk("R3 byte enable off", v, 32'h1);
    wr(2'd0, 4'b0001, 32'h1);
    rd(2'd0, v); chk("R3 clear bit0", v, 32'h0);

    // R4 fresh CE after clear captures again, address bit 32 set
    pulse(5'b00001, a4, 1'b0, 8'h3C);
    rd(2'd1, v); chk("R4 recapture ptr", v, ptrOf(a4, 1'b0));
    rd(2'd2, v); chk("R4 recapture ext", v, extOf(a4, 8'h3C));
    wr(2'd0, 4'b0011, 32'hFFFF);

    // R7 command readback mask
    wr(2'd0, 4'b1100, 32'hFFFF_0000);
    rd(2'd0, v); chk("R7 cmd mask", v, 32'h0B03_0000);
    wr(2'd0, 4'b0100, 32'h0000_0000);
    rd(2'd0, v); chk("R7 cmd low byte", v, 32'h0B00_0000);
    wr(2'd0, 4'b1100, 32'h0);

    // R2 R8 sweep each event class against its enable
    for (int i = 0; i < 5; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [15:0] bm;
        bm = 16'(1) << evBits[i];
        wr(2'd0, 4'b1100, {(en != 0) ? bm : 16'h0, 16'h0});
        pulse(5'(1) << i, a3, 1'b0, 8'h00);
        rd(2'd0, v); chk("R2 event bit", {16'h0, v[15:0]}, {16'h0, bm});
        chk("R8 serr not yet", {31'b0, serr}, 32'h0);
        @(negedge clk);
        chk("R8 serr raised", {31'b0, serr}, 32'(en));
        wr(2'd0, 4'b0011, 32'hFFFF);
        chk("R8 serr one cycle after clear", {31'b0, serr}, 32'(en));
        @(negedge clk);
        chk("R8 serr dropped", {31'b0, serr}, 32'h0);
      end
    end
    wr(2'd0, 4'b1100, 32'h0);

    // R9 event wins over a same-cycle clear
    pulse(5'b00001, a1, 1'b0, 8'h01);
    pulse(5'b10000, a1, 1'b0, 8'h01);
    @(negedge clk);
    ceEvt = 1; thmEvt = 1;
    wrEn = 1; regSel = 2'd0; byteEn = 4'b0011; wrData = 32'h0000_0801;
    @(negedge clk);
    ceEvt = 0; thmEvt = 0; wrEn = 0; byteEn = '0;
    rd(2'd0, v); chk("R9 event wins", v, 32'h0000_0801);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule